// File: doc/BRIEF.md
# Floating-Point Control and Status Word Unit

This block holds the floating-point control and status word for a processor's FPU. The word has four software-visible windows, each chosen by a 5-bit register number. Number 31 is the whole word. Number 25 is a compact view of the condition-code bits. Number 26 is a view of the cause and sticky-flag fields. Number 28 is a view of the enables, the rounding mode and the flush bit. A write through a partial window changes only the bits that window owns, and those bits land in scattered positions of the word. A write whose reserved bits are non-zero is dropped as a whole.

Arithmetic units report each completed operation with a raw flag vector in library bit order, plus an unimplemented-operation indication. The block reorders these into the architectural 5-bit flag layout and replaces the cause field with the result. It then either requests a floating-point exception, when a cause is enabled, or ORs the flags into the sticky field. The request also follows any accepted software write that leaves an enabled cause set. The unimplemented-operation cause requests an exception whatever the enables are. The current rounding mode is decoded onto its own output, and a combinational read port returns any of the four views.

Word layout:
- bits 31:25 are condition codes 7..1.
- bit 24 is the flush bit.
- bit 23 is condition code 0.
- bits 22:18 are reserved.
- bits 17:12 are the cause field; bit 17 is unimplemented.
- bits 11:7 are the enables.
- bits 6:2 are the sticky flags.
- bits 1:0 are the rounding mode.

In every 5-bit group the flag order is inexact at bit 0, underflow at 1, overflow at 2, divide-by-zero at 3 and invalid at 4.

Top module: `fcsr_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the word reads zero and the exception request is low until the first event.
- R2: A write to number 25 is dropped if any data bit above bit 7 is set. Otherwise data bits 7:1 replace word bits 31:25, data bit 0 replaces word bit 23, and all other word bits keep their value.
- R3: A write to number 26 is dropped if any data bit 22:18 is set. Otherwise only word bits 17:12 and 6:2 take the data's same-position bits.
- R4: A write to number 28 is dropped if any data bit 22:18 is set. Otherwise word bits 11:7 and 1:0 take the data's same-position bits, and data bit 2 replaces word bit 24.
- R5: A write to number 31 replaces the whole word unless data bits 22:18 are non-zero. A write to any other number changes nothing.
- R6: In the cycle after an accepted write, `exc_req` is high for one cycle exactly when new word bits 17:12 AND {1, new word bits 11:7} is non-zero.
- R7: `round_mode` equals word bits 1:0, where 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity.
- R8: Raw flag input bits map as follows: bit 5 (inexact) to group bit 0, bit 4 (underflow) to group bit 1, bit 3 (overflow) to group bit 2, bit 2 (divide-by-zero) to group bit 3 and bit 0 (invalid) to group bit 4. Raw bit 1 is ignored.
- R9: On an operation report, the mapped flags, with the unimplemented indication at cause bit 5, replace word bits 17:12. If that cause AND {1, enables} is non-zero, `exc_req` is high the next cycle and the sticky flags are unchanged. Otherwise the cause's low five bits are ORed into word bits 6:2. Enables, rounding mode and condition codes never change on a report.
- R10: When an accepted write and an operation report arrive in the same cycle, the write takes effect and the report is discarded. A rejected write does not block a report.
- R11: The read port returns the following, with all other bits zero:
  - for 31, the whole word;
  - for 25, word bits 31:25 at bits 7:1 and word bit 23 at bit 0;
  - for 26, word bits 17:12 and 6:2 in place;
  - for 28, word bits 11:7 and 1:0 in place and word bit 24 at bit 2;
  - for any other number, zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 5 | Register number of the write |
| wr_data | input | 32 | Write value in the selected view's layout |
| op_done | input | 1 | An arithmetic operation completed this cycle |
| op_flags | input | 6 | Raw flags in library order (see R8) |
| op_unimpl | input | 1 | The operation was unimplemented |
| rd_sel | input | 5 | Register number of the read view |
| rd_data | output | 32 | Selected view of the word |
| fcsr | output | 32 | Full current word |
| round_mode | output | 2 | Decoded rounding mode |
| exc_req | output | 1 | Floating-point exception request, one-cycle pulse |

## Verification
Every cycle, the embedded properties check several things:
- a rejected full-word write leaves the word untouched;
- an accepted full-word write lands whole;
- an unimplemented report always yields a request;
- operation reports never clear sticky flags or touch enables, rounding mode or condition codes.

Only the bench's scenarios can show the exact bit scatter of the partial windows, the flag reordering for each single flag, the read-view reassembly and the write-over-report priority. It compares these against a reference model across random writes, reports and reads.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int SEL_W    = 5;
  localparam int WORD_W   = 32;
  localparam int NFLAG    = 5;
  localparam int CAUSE_W  = NFLAG + 1;
  localparam int RAW_W    = 6;
  localparam int FLG_LO   = 2;
  localparam int ENA_LO   = FLG_LO + NFLAG;
  localparam int CAU_LO   = ENA_LO + NFLAG;
  localparam int CAU_HI   = CAU_LO + CAUSE_W - 1;
  localparam int RSV_LO   = CAU_HI + 1;
  localparam int RSV_HI   = RSV_LO + 4;
  localparam int CC0_POS  = RSV_HI + 1;
  localparam int FLUSH_POS = CC0_POS + 1;
  localparam int CCH_LO   = FLUSH_POS + 1;

  localparam logic [SEL_W-1:0] SEL_CC   = 5'd25;
  localparam logic [SEL_W-1:0] SEL_EXC  = 5'd26;
  localparam logic [SEL_W-1:0] SEL_ENA  = 5'd28;
  localparam logic [SEL_W-1:0] SEL_FULL = 5'd31;

  // raw input bit feeding each architectural flag position 0..4
  localparam int RAW_POS [NFLAG] = '{5, 4, 3, 2, 0};

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_PINF   = 2'd2,
    RM_TO_NINF   = 2'd3
  } rmode_e;
endpackage

// File: rtl/fcsr_rst_sync.sv
module fcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fcsr_flag_map.sv
module fcsr_flag_map
  import fcsr_pkg::*;
(
  input  logic [RAW_W-1:0]   raw_flags,
  input  logic               unimpl,
  output logic [CAUSE_W-1:0] cause
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_map
    assign cause[g] = raw_flags[RAW_POS[g]];
  end
  assign cause[CAUSE_W-1] = unimpl;
endmodule

// File: rtl/fcsr_wr_merge.sv
module fcsr_wr_merge
  import fcsr_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] data,
  input  logic [WORD_W-1:0] cur,
  output logic              accept,
  output logic [WORD_W-1:0] merged
);
  logic rsv_clear;
  assign rsv_clear = (data[RSV_HI:RSV_LO] == '0);

  always_comb begin
    accept = 1'b0;
    merged = cur;
    unique case (sel)
      SEL_CC: begin
        accept = (data[WORD_W-1:8] == '0);
        merged[WORD_W-1:CCH_LO] = data[7:1];
        merged[CC0_POS]         = data[0];
      end
      SEL_EXC: begin
        accept = rsv_clear;
        merged[CAU_HI:CAU_LO]         = data[CAU_HI:CAU_LO];
        merged[ENA_LO-1:FLG_LO]       = data[ENA_LO-1:FLG_LO];
      end
      SEL_ENA: begin
        accept = rsv_clear;
        merged[CAU_LO-1:ENA_LO] = data[CAU_LO-1:ENA_LO];
        merged[1:0]             = data[1:0];
        merged[FLUSH_POS]       = data[2];
      end
      SEL_FULL: begin
        accept = rsv_clear;
        merged = data;
      end
      default: begin
        accept = 1'b0;
        merged = cur;
      end
    endcase
  end
endmodule

// File: rtl/fcsr_rd_view.sv
module fcsr_rd_view
  import fcsr_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] cur,
  output logic [WORD_W-1:0] view
);
  always_comb begin
    view = '0;
    unique case (sel)
      SEL_CC: begin
        view[7:1] = cur[WORD_W-1:CCH_LO];
        view[0]   = cur[CC0_POS];
      end
      SEL_EXC: begin
        view[CAU_HI:CAU_LO]   = cur[CAU_HI:CAU_LO];
        view[ENA_LO-1:FLG_LO] = cur[ENA_LO-1:FLG_LO];
      end
      SEL_ENA: begin
        view[CAU_LO-1:ENA_LO] = cur[CAU_LO-1:ENA_LO];
        view[1:0]             = cur[1:0];
        view[2]               = cur[FLUSH_POS];
      end
      SEL_FULL: view = cur;
      default:  view = '0;
    endcase
  end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              op_done,
  input  logic [RAW_W-1:0]  op_flags,
  input  logic              op_unimpl,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] fcsr,
  output logic [1:0]        round_mode,
  output logic              exc_req
);
  logic              rst_n_s;
  logic [WORD_W-1:0] word_q, word_d;
  logic              exc_q, exc_d;
  logic              word_en;
  logic              wr_accept;
  logic [WORD_W-1:0] wr_word;
  logic [CAUSE_W-1:0] op_cause;
  logic [CAUSE_W-1:0] trap_mask;
  logic              op_trap;
  logic              take_wr, take_op;
  rmode_e            rm;

  fcsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fcsr_wr_merge u_merge (
    .sel(wr_sel), .data(wr_data), .cur(word_q),
    .accept(wr_accept), .merged(wr_word)
  );

  fcsr_flag_map u_map (
    .raw_flags(op_flags), .unimpl(op_unimpl), .cause(op_cause)
  );

  fcsr_rd_view u_view (
    .sel(rd_sel), .cur(word_q), .view(rd_data)
  );

  assign take_wr   = wr_en && wr_accept;
  assign take_op   = op_done && !take_wr;
  // unimplemented cause always traps
  assign trap_mask = {1'b1, word_q[CAU_LO-1:ENA_LO]};
  assign op_trap   = |(op_cause & trap_mask);

  always_comb begin
    word_d  = word_q;
    exc_d   = 1'b0;
    word_en = 1'b0;
    if (take_wr) begin
      word_en = 1'b1;
      word_d  = wr_word;
      exc_d   = |(wr_word[CAU_HI:CAU_LO] & {1'b1, wr_word[CAU_LO-1:ENA_LO]});
    end else if (take_op) begin
      word_en = 1'b1;
      word_d[CAU_HI:CAU_LO] = op_cause;
      if (op_trap) exc_d = 1'b1;
      else word_d[ENA_LO-1:FLG_LO] = word_q[ENA_LO-1:FLG_LO] | op_cause[NFLAG-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) exc_q <= 1'b0;
    else          exc_q <= exc_d;
  end

  assign rm         = rmode_e'(word_q[1:0]);
  assign round_mode = rm;
  assign fcsr       = word_q;
  assign exc_req    = exc_q;

  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == SEL_FULL && wr_data[RSV_HI:RSV_LO] != '0 && !op_done)
      |=> $stable(fcsr)) else $error("full write with reserved bits changed word"); // R5
  AST_FULL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sel == SEL_FULL && wr_data[RSV_HI:RSV_LO] == '0)
      |=> fcsr == $past(wr_data)) else $error("full write not applied"); // R5
  AST_UNIMPL_TRAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_done && op_unimpl && !wr_en) |=> exc_req) else $error("unimplemented did not trap"); // R9
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_done && !wr_en) |=>
      ((fcsr[ENA_LO-1:FLG_LO] & $past(fcsr[ENA_LO-1:FLG_LO])) == $past(fcsr[ENA_LO-1:FLG_LO])))
    else $error("sticky flag cleared by report"); // R9
  AST_REPORT_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_done && !wr_en) |=> ($stable(fcsr[CAU_LO-1:0]) == 1'b1 || $stable(fcsr[CAU_LO-1:ENA_LO]))
      && $stable(fcsr[1:0]) && $stable(fcsr[WORD_W-1:RSV_LO]))
    else $error("report touched control bits"); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_en && !op_done) |=> !exc_req) else $error("request without event"); // R6
endmodule

// File: tb/fcsr_unit_tb_top.sv
module fcsr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_sel;
  logic [31:0] wr_data;
  logic        op_done;
  logic [5:0]  op_flags;
  logic        op_unimpl;
  logic [4:0]  rd_sel;
  logic [31:0] rd_data, fcsr;
  logic [1:0]  round_mode;
  logic        exc_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_word;
  logic        m_exc;
  string       m_tag;

  always #5 clk = ~clk;

  fcsr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .op_done(op_done), .op_flags(op_flags), .op_unimpl(op_unimpl), .rd_sel(rd_sel),
    .rd_data(rd_data), .fcsr(fcsr), .round_mode(round_mode), .exc_req(exc_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] map_flags(input logic [5:0] r, input logic u);
    return {u, r[0], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic [31:0] view_of(input logic [4:0] s, input logic [31:0] w);
    logic [31:0] v = '0;
    case (s)
      5'd25: begin v[7:1] = w[31:25]; v[0] = w[23]; end
      5'd26: begin v[17:12] = w[17:12]; v[6:2] = w[6:2]; end
      5'd28: begin v[11:7] = w[11:7]; v[1:0] = w[1:0]; v[2] = w[24]; end
      5'd31: v = w;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic merge_ok(input logic [4:0] s, input logic [31:0] d);
    case (s)
      5'd25: return d[31:8] == '0;
      5'd26, 5'd28, 5'd31: return d[22:18] == '0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] merge_w(input logic [4:0] s, input logic [31:0] d,
                                           input logic [31:0] w);
    logic [31:0] n = w;
    case (s)
      5'd25: begin n[31:25] = d[7:1]; n[23] = d[0]; end
      5'd26: begin n[17:12] = d[17:12]; n[6:2] = d[6:2]; end
      5'd28: begin n[11:7] = d[11:7]; n[1:0] = d[1:0]; n[24] = d[2]; end
      5'd31: n = d;
      default: n = w;
    endcase
    return n;
  endfunction

  // check the state from the previous edge, drive new inputs, predict next
  task automatic step(input logic we, input logic [4:0] ws, input logic [31:0] wd,
                      input logic od, input logic [5:0] of, input logic ou,
                      input logic [4:0] rs);
    logic [5:0] c;
    @(negedge clk);
    chk({m_tag, " word"}, fcsr, m_word);
    chk((m_tag == "R9" || m_tag == "R8") ? "R9 exc_req" : "R6 exc_req", {31'b0, exc_req}, {31'b0, m_exc});
    chk("R7 round_mode", {30'b0, round_mode}, {30'b0, m_word[1:0]});
    wr_en = we; wr_sel = ws; wr_data = wd;
    op_done = od; op_flags = of; op_unimpl = ou; rd_sel = rs;
    #1;
    chk("R11 rd_data", rd_data, view_of(rs, m_word));
    m_exc = 1'b0;
    if (we && merge_ok(ws, wd)) begin
      m_word = merge_w(ws, wd, m_word);
      m_exc  = |(m_word[17:12] & {1'b1, m_word[11:7]});
      m_tag  = (od) ? "R10" : (ws == 5'd25) ? "R2" : (ws == 5'd26) ? "R3" :
               (ws == 5'd28) ? "R4" : "R5";
    end else if (od) begin
      c = map_flags(of, ou);
      m_word[17:12] = c;
      if (|(c & {1'b1, m_word[11:7]})) m_exc = 1'b1;
      else m_word[6:2] = m_word[6:2] | c[4:0];
      m_tag = we ? "R10" : "R9";
    end else begin
      m_tag = !we ? "R9" : (ws == 5'd25) ? "R2" : (ws == 5'd26) ? "R3" :
              (ws == 5'd28) ? "R4" : "R5";
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd7321);
    m_word = '0; m_exc = 1'b0; m_tag = "R1";
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0;
    op_done = 0; op_flags = 0; op_unimpl = 0; rd_sel = 5'd31;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 word in reset", fcsr, 32'h0);
    chk("R1 exc in reset", {31'b0, exc_req}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // directed corner cases
    step(1, 5'd31, 32'h0000_0003, 0, 0, 0, 5'd31);            // rm toward -inf
    step(1, 5'd25, 32'h0000_01AB, 0, 0, 0, 5'd25);            // R2 reject bit 8
    step(1, 5'd25, 32'h0000_00AB, 0, 0, 0, 5'd25);            // R2 accept
    step(1, 5'd26, 32'h0010_3004, 0, 0, 0, 5'd26);            // R3 reject bit 20
    step(1, 5'd26, 32'h0000_007C, 0, 0, 0, 5'd26);            // R3 accept flags
    step(1, 5'd28, 32'h0004_0F87, 0, 0, 0, 5'd28);            // R4 reject bit 18
    step(1, 5'd28, 32'h0000_0006, 0, 0, 0, 5'd28);            // R4 flush + rm 2
    step(1, 5'd27, 32'hFFFF_FFFF, 0, 0, 0, 5'd27);            // R5 other number
    step(1, 5'd31, 32'h0000_0002, 0, 0, 0, 5'd31);            // clear
    for (int k = 0; k < 6; k++) begin                        // R8 each raw bit
      step(0, 0, 0, 1, 6'(1 << k), 0, 5'd26);
      step(1, 5'd31, 32'h0, 0, 0, 0, 5'd26);
    end
    step(0, 0, 0, 1, 6'h00, 1, 5'd26);                        // R9 unimpl traps
    step(1, 5'd28, 32'h0000_0F80, 0, 0, 0, 5'd28);            // all enables
    step(0, 0, 0, 1, 6'h20, 0, 5'd26);                        // R9 enabled trap
    step(1, 5'd26, 32'h0000_1000, 0, 0, 0, 5'd31);            // R6 write-trap
    step(1, 5'd31, 32'h0000_0000, 1, 6'h3D, 0, 5'd31);        // R10 write wins
    step(1, 5'd31, 32'h0004_0000, 1, 6'h08, 0, 5'd31);        // R10 rejected write
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [4:0]  s;
      int pick;
      pick = $urandom_range(0, 9);
      s = (pick < 2) ? 5'd25 : (pick < 4) ? 5'd26 : (pick < 6) ? 5'd28 :
          (pick < 8) ? 5'd31 : 5'($urandom);
      d = $urandom;
      if ($urandom_range(0, 3) != 0) begin
        d[22:18] = '0;
        if (s == 5'd25) d[31:8] = '0;
      end
      step($urandom_range(0, 2) == 0, s, d, $urandom_range(0, 1) == 1, 6'($urandom),
           $urandom_range(0, 7) == 0, 5'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 5'd31);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule